// File: doc/BRIEF.md
# Delayed Power-Down Controller

This block sequences a power-down that software can still cancel. A press on the button input loads a delay, given in milliseconds by a separate time-set register, into a countdown. A 1 ms tick decrements the countdown. When it expires, the block raises a one-cycle power-down request. Until then, software can abort the sequence or reload the full delay through self-clearing command bits in one control register. The same register can also request an immediate power-down.

The register is also the source of a forced watchdog-timeout event, which is a one-cycle pulse. Software raises it with a command bit. When the enable bit is set, a rising edge on the external keyboard-controller line raises it as well. The line can stay high for a long time, so it is synchronized and edge-detected, and each rise gives exactly one event. The watchdog counter that consumes the event is outside this block.

Top module: `pdn_ctrl`

## Requirements
- R1: After reset, `pdown_o` and `wdt_evt_o` are 0, the countdown is idle and `rd_data_o` reads 0x20.
- R2: A button press while the countdown is idle loads `delay_ms_i` and starts it. The countdown expires on the N-th tick after loading, where N is the loaded delay (N = 0 behaves as 1). `pdown_o` is high for exactly the one cycle after the clock edge that samples that tick.
- R3: A button press while the countdown is running is ignored and does not reload it.
- R4: Writing 1 to bit 5 stops a running countdown without any power-down request. The bit holds nothing written: on read, bit 5 is 1 when the countdown is idle or stopped.
- R5: On read, bit 5 is 0 while the countdown is running.
- R6: Writing 1 to bit 6 reloads the full `delay_ms_i` and runs the countdown. This can be repeated without limit, and bit 6 always reads 0.
- R7: When bits 5 and 6 are written to 1 together, the stop wins and the countdown ends idle.
- R8: Writing 1 to bit 7 makes `pdown_o` high for the one cycle after the write edge. Bit 7 reads 0.
- R9: Writing 1 to bit 2 makes `wdt_evt_o` high for the one cycle after the write edge. Bit 2 reads 0.
- R10: With bit 3 (line enable) at 1, a rising edge on `kbd_line_i` makes `wdt_evt_o` high for exactly one cycle, three clock edges after the rise is first sampled, however long the line stays high. With bit 3 at 0, the line has no effect.
- R11: Bits 4, 1 and 0 read 0 and ignore writes. Bit 3 reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| button_i | input | 1 | Synchronous button level; a rise is a press |
| kbd_line_i | input | 1 | Asynchronous keyboard-controller line |
| delay_ms_i | input | DLY_W | Programmed delay in ms |
| tick_1ms_i | input | 1 | One-cycle 1 ms tick |
| pdown_o | output | 1 | Power-down request pulse |
| wdt_evt_o | output | 1 | Forced watchdog-timeout pulse |

## Verification
A write of bits 2 or 7, and the sampling of the final tick, show up on the pulse outputs in the cycle right after that edge. A rise on the keyboard line shows up after three edges. Countdown state shows up on read bit 5 right after the edge that loads or stops it. Each task drives its inputs just after a rising edge and checks a short delay later. It counts edges explicitly, so every check looks at the exact cycle its result is due and, for pulses, also at the cycle after.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  localparam int REG_W       = 8;
  localparam int BIT_FORCE   = 2;
  localparam int BIT_EXT_EN  = 3;
  localparam int BIT_STOP    = 5;
  localparam int BIT_RESTART = 6;
  localparam int BIT_SPOFF   = 7;

  typedef struct packed {
    logic force_wdt;
    logic stop;
    logic restart;
    logic spoff;
  } cmd_t;
endpackage

// File: rtl/pdn_edge_det.sv
module pdn_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic lvl;
  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign lvl = d_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else if (SYNC_STAGES == 1) sync_q <= d_i;
        else sync_q <= {sync_q[SYNC_STAGES-2:0], d_i};
      end
      assign lvl = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= lvl;
  end

  assign rise_o = lvl & ~prev_q;
endmodule

// File: rtl/pdn_ctrl_reg.sv
module pdn_ctrl_reg
  import pdn_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             running_i,
  output cmd_t             cmd_o,
  output logic             ext_en_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic ext_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_en_q <= 1'b0;
    else if (wr_en_i) ext_en_q <= wr_data_i[BIT_EXT_EN];
  end

  // command bits are write strobes only; nothing is stored
  always_comb begin
    cmd_o.force_wdt = wr_en_i & wr_data_i[BIT_FORCE];
    cmd_o.stop      = wr_en_i & wr_data_i[BIT_STOP];
    cmd_o.restart   = wr_en_i & wr_data_i[BIT_RESTART];
    cmd_o.spoff     = wr_en_i & wr_data_i[BIT_SPOFF];
  end

  always_comb begin
    rd_data_o             = '0;
    rd_data_o[BIT_EXT_EN] = ext_en_q;
    rd_data_o[BIT_STOP]   = ~running_i;
  end

  assign ext_en_o = ext_en_q;
endmodule

// File: rtl/pdn_delay_cnt.sv
module pdn_delay_cnt #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             press_i,
  input  logic             stop_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             running_o,
  output logic             expire_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             run_q;
  logic             last;

  assign last     = (cnt_q <= DLY_W'(1));
  assign expire_o = run_q & tick_i & last & ~stop_i & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (restart_i || (press_i && !run_q)) begin
      cnt_q <= delay_i;
      run_q <= 1'b1;
    end else if (run_q && tick_i) begin
      if (last) run_q <= 1'b0;
      else      cnt_q <= cnt_q - DLY_W'(1);
    end
  end

  assign running_o = run_q;
endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl
  import pdn_pkg::*;
#(
  parameter int DLY_W     = 16,
  parameter int EXT_SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             button_i,
  input  logic             kbd_line_i,
  input  logic [DLY_W-1:0] delay_ms_i,
  input  logic             tick_1ms_i,
  output logic             pdown_o,
  output logic             wdt_evt_o
);
  cmd_t cmd;
  logic ext_en, running, expire, press, ext_rise;
  logic pdown_q, wdt_q;

  pdn_ctrl_reg u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .running_i(running), .cmd_o(cmd), .ext_en_o(ext_en), .rd_data_o(rd_data_o)
  );

  pdn_edge_det #(.SYNC_STAGES(0)) u_btn_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(button_i), .rise_o(press)
  );

  pdn_edge_det #(.SYNC_STAGES(EXT_SYNC)) u_ext_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(kbd_line_i), .rise_o(ext_rise)
  );

  pdn_delay_cnt #(.DLY_W(DLY_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .press_i(press), .stop_i(cmd.stop),
    .restart_i(cmd.restart), .tick_i(tick_1ms_i), .delay_i(delay_ms_i),
    .running_o(running), .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdown_q <= 1'b0;
      wdt_q   <= 1'b0;
    end else begin
      pdown_q <= expire | cmd.spoff;
      wdt_q   <= cmd.force_wdt | (ext_rise & ext_en);
    end
  end

  assign pdown_o   = pdown_q;
  assign wdt_evt_o = wdt_q;
endmodule

// File: rtl/pdn_ctrl_chk.sv
module pdn_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       button_i,
  input logic       tick_1ms_i,
  input logic       pdown_o,
  input logic       wdt_evt_o
);
  a_r8_spoff_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[7] |=> pdown_o);

  a_r9_force_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[2] |=> wdt_evt_o);

  // R4 and R7: any stop write leaves the countdown idle
  a_r4_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[5] |=> rd_data_o[5]);

  a_r5_start_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[5]) |-> $past(button_i || (wr_en_i && wr_data_i[6])));

  a_r2_expiry_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_o && !$past(wr_en_i && wr_data_i[7]) |-> $past(!rd_data_o[5] && tick_1ms_i));

  a_r10_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_evt_o && !$past(wr_en_i && wr_data_i[2]) |-> $past(rd_data_o[3]));
endmodule

bind pdn_ctrl pdn_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .button_i(button_i), .tick_1ms_i(tick_1ms_i),
  .pdown_o(pdown_o), .wdt_evt_o(wdt_evt_o)
);

// File: tb/pdn_ctrl_tb.sv
module pdn_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, button = 1'b0, kbd = 1'b0, tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic [DLY_W-1:0] delay = 16'd3;
  logic [7:0] rd_data;
  logic pdown, wdt;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdn_ctrl #(.DLY_W(DLY_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .button_i(button), .kbd_line_i(kbd),
    .delay_ms_i(delay), .tick_1ms_i(tick), .pdown_o(pdown), .wdt_evt_o(wdt)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; cyc(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic press();
    button = 1'b1; cyc(); button = 1'b0;
  endtask

  task automatic do_tick();
    tick = 1'b1; cyc(); tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pdown", 8'(pdown), 8'h0);
    chk("R1 wdt", 8'(wdt), 8'h0);
    chk("R1 rd", rd_data, 8'h20);
  endtask

  task automatic t_expire();
    delay = 16'd3;
    press();
    chk("R5 running", 8'(rd_data[5]), 8'h0);
    do_tick(); chk("R2 tick1", 8'(pdown), 8'h0);
    do_tick(); chk("R2 tick2", 8'(pdown), 8'h0);
    do_tick(); chk("R2 tick3", 8'(pdown), 8'h1);
    cyc();     chk("R2 one cycle", 8'(pdown), 8'h0);
    chk("R2 idle after", 8'(rd_data[5]), 8'h1);
  endtask

  task automatic t_press_ignored();
    press(); do_tick(); do_tick();
    press();
    do_tick(); chk("R3 no reload", 8'(pdown), 8'h1);
    cyc();
  endtask

  task automatic t_restart();
    press(); do_tick(); do_tick();
    wr(8'h40); chk("R6 reads 0", 8'(rd_data[6]), 8'h0);
    do_tick(); do_tick(); wr(8'h40);
    do_tick(); chk("R6 held t1", 8'(pdown), 8'h0);
    do_tick(); chk("R6 held t2", 8'(pdown), 8'h0);
    do_tick(); chk("R6 full delay", 8'(pdown), 8'h1);
    cyc();
  endtask

  task automatic t_stop();
    int n = 0;
    press(); do_tick();
    wr(8'h20);
    chk("R4 stopped", 8'(rd_data[5]), 8'h1);
    for (int i = 0; i < 5; i++) begin do_tick(); n += int'(pdown); end
    chk("R4 no pdown", 8'(n), 8'h0);
  endtask

  task automatic t_stop_restart();
    int n = 0;
    press();
    wr(8'h60);
    chk("R7 stop wins", 8'(rd_data[5]), 8'h1);
    for (int i = 0; i < 5; i++) begin do_tick(); n += int'(pdown); end
    chk("R7 no pdown", 8'(n), 8'h0);
  endtask

  task automatic t_spoff();
    wr(8'h80);
    chk("R8 pulse", 8'(pdown), 8'h1);
    chk("R8 reads 0", 8'(rd_data[7]), 8'h0);
    cyc(); chk("R8 one cycle", 8'(pdown), 8'h0);
  endtask

  task automatic t_force();
    wr(8'h04);
    chk("R9 pulse", 8'(wdt), 8'h1);
    chk("R9 reads 0", 8'(rd_data[2]), 8'h0);
    cyc(); chk("R9 one cycle", 8'(wdt), 8'h0);
  endtask

  task automatic t_ext_line();
    int n = 0;
    wr(8'h08);
    kbd = 1'b1;
    cyc(); chk("R10 e1", 8'(wdt), 8'h0);
    cyc(); chk("R10 e2", 8'(wdt), 8'h0);
    cyc(); chk("R10 e3", 8'(wdt), 8'h1);
    for (int i = 0; i < 10; i++) begin cyc(); n += int'(wdt); end
    chk("R10 single event", 8'(n), 8'h0);
    kbd = 1'b0; cyc(); cyc(); cyc();
    wr(8'h00);
    kbd = 1'b1; n = 0;
    for (int i = 0; i < 8; i++) begin cyc(); n += int'(wdt); end
    chk("R10 disabled", 8'(n), 8'h0);
    kbd = 1'b0; cyc(); cyc(); cyc();
  endtask

  task automatic t_reserved();
    wr(8'h13);
    chk("R11 rsvd", rd_data, 8'h20);
    chk("R11 no side effect", 8'({pdown, wdt}), 8'h0);
    wr(8'h1B);
    chk("R11 enable readback", rd_data, 8'h28);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    rst_n = 1'b1;
    cyc(); cyc();
    t_reset();
    t_expire();
    t_press_ignored();
    t_restart();
    t_stop();
    t_stop_restart();
    t_spoff();
    t_force();
    t_ext_line();
    t_reserved();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule